// File: doc/BRIEF.md
# Two-Way Data Cache Controller with Line Locking

This block sits between a processor's load/store port and a simple word-wide memory port. It holds 128 sets of two lines by default. Each line holds four 32-bit words and carries a physical tag plus valid, dirty and lock flags. Each set has one recency bit. A read that hits returns its word one cycle after the request is accepted. A miss refills the whole line with a four-beat burst. If the chosen line is dirty, it is first copied back with its own four-beat burst.

Every request carries its own attributes:
- A write-policy bit selects write-through or copy-back for that access only.
- An inhibit bit sends the access straight to memory and leaves the array untouched.
- Lock and unlock bits set or clear the lock flag of the line the access ends up in.

When choosing a victim, the controller takes an empty way first. Otherwise it takes the least recently used way, unless that way is locked, in which case it takes the other way. If both ways are locked, the access is served as a single uncached transfer and no line is allocated.

The controller has five states:
- `ST_IDLE` accepts requests and serves hits.
- `ST_WBACK` copies a dirty victim back to memory.
- `ST_FILL` refills the line.
- `ST_DONE` answers a refilled access.
- `ST_SINGLE` performs one uncached transfer.

The transitions are:
- IDLE→SINGLE on an inhibited access, a write-through write, or a miss with no free victim.
- IDLE→WBACK on a miss whose victim is dirty.
- IDLE→FILL on a miss whose victim is clean or empty.
- IDLE→IDLE on any other hit.
- WBACK→FILL on the fourth write-back acknowledge.
- FILL→DONE on the fourth refill acknowledge.
- DONE→IDLE unconditionally.
- SINGLE→IDLE on the acknowledge.

Top module: `dcache_2way`

## Requirements
- R1: After reset the controller is in ST_IDLE with `req_ready`=1, `rsp_valid`=0 and `mem_req`=0, and no line is valid, so the first read of any address refills its line.
- R2: A read hit, or a copy-back write hit, raises `rsp_valid` in the cycle after acceptance. A read returns the newest value written to that word. At most one way matches a lookup.
- R3: A read miss with a clean or empty victim issues four burst reads (`mem_burst`=1, `mem_write`=0) at line base + 0, 4, 8 and 12 in ascending order. Address bits [3:2] select the word, bits [10:4] the set and bits [31:11] the tag. The response comes one cycle after the cycle following the last acknowledge, which is six cycles after acceptance with a zero-wait memory.
- R4: The victim is an invalid way if one exists. Otherwise it is the way not used by the most recent hit or refill in that set.
- R5: `req_lock`=1 locks the line that an access hits or refills, and `req_unlock`=1 clears that lock. A locked line is never chosen as a victim.
- R6: A cacheable miss in a set whose two lines are both locked is served as one transfer with `mem_burst`=0 and allocates nothing.
- R7: With `req_wthru`=0, a write hit updates only the array and marks the line dirty. A write miss refills the line and then writes into it, and memory is left unchanged.
- R8: A dirty victim is written back as four burst writes in ascending word order, all of them before the first refill read.
- R9: With `req_wthru`=1, a write hit updates the line and also performs one single memory write. A write miss performs only the single write and allocates nothing. In both cases the response comes one cycle after the acknowledge.
- R10: With `req_inhibit`=1 the access is one single memory transfer. It neither allocates nor alters any line, and a read returns `mem_rdata`.
- R11: Once `mem_req` is raised, `mem_req`, `mem_addr` and `mem_write` hold until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller can take a request (ST_IDLE) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Store data |
| req_wthru | input | 1 | 1 = write-through, 0 = copy-back for this access |
| req_inhibit | input | 1 | 1 = bypass the array |
| req_lock | input | 1 | Lock the line this access hits or refills |
| req_unlock | input | 1 | Unlock the line this access hits or refills |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = memory write |
| mem_burst | output | 1 | Beat is part of a four-beat line burst |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write data for this beat |
| mem_ack | input | 1 | Beat completes at this clock edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The properties assume three things about the inputs:
- The processor presents a request only through the ready handshake, and only one request is outstanding at a time.
- Memory raises `mem_ack` only while `mem_req` is high.
- No address is accessed both cached and with `req_inhibit`, so an inhibited read never bypasses a dirty copy.

The stimulus keeps within these limits as follows. A blocking task issues each request and waits for its response before the next one. The memory model acknowledges only pending requests, with a random delay. Inhibited traffic uses tags 6 and 7, which cacheable traffic never uses.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_DONE,
        ST_SINGLE
    } dc_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic lock;
    } dc_flags_t;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store
    import dc_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int TAG_W = 21,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output dc_flags_t        rd_flags [2],
    output logic [TAG_W-1:0] rd_tag   [2],
    output logic             rd_lru,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_way,
    input  dc_flags_t        wr_flags,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             lru_en,
    input  logic [IDX_W-1:0] lru_idx,
    input  logic             lru_used_way
);

    logic [SETS-1:0] lru_q;   // per set: index of least recently used way

    for (genvar w = 0; w < 2; w++) begin : g_way
        dc_flags_t        flags_q [SETS];
        logic [TAG_W-1:0] tags_q  [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) flags_q[s] <= '0;
            end else if (wr_en && wr_way == 1'(w)) begin
                flags_q[wr_idx] <= wr_flags;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) tags_q[wr_idx] <= wr_tag;
        end

        assign rd_flags[w] = flags_q[rd_idx];
        assign rd_tag[w]   = tags_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lru_q <= '0;
        else if (lru_en) lru_q[lru_idx] <= ~lru_used_way;
    end

    assign rd_lru = lru_q[rd_idx];

    // R5: a lock flag is only ever stored on a valid line
    a_r5_lock_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_flags.lock) |-> wr_flags.valid);

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int SETS   = 128,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS),
    parameter int WRD_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WRD_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WRD_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = 2 * SETS * WORDS;
    localparam int AW    = 1 + IDX_W + WRD_W;

    logic [DATA_W-1:0] arr_q [DEPTH];
    logic [AW-1:0]     rd_a;
    logic [AW-1:0]     wr_a;

    assign rd_a    = {rd_way, rd_idx, rd_word};
    assign wr_a    = {wr_way, wr_idx, wr_word};
    assign rd_data = arr_q[rd_a];

    always_ff @(posedge clk) begin
        if (wr_en) arr_q[wr_a] <= wr_data;
    end

endmodule

// File: rtl/dc_victim_sel.sv
module dc_victim_sel (
    input  logic [1:0] valid_vec,
    input  logic [1:0] lock_vec,
    input  logic       lru_way,
    output logic       vic_ok,
    output logic       vic_way
);

    always_comb begin
        vic_ok  = 1'b1;
        vic_way = 1'b0;
        if (!valid_vec[0]) begin
            vic_way = 1'b0;
        end else if (!valid_vec[1]) begin
            vic_way = 1'b1;
        end else if (!lock_vec[lru_way]) begin
            vic_way = lru_way;
        end else if (!lock_vec[~lru_way]) begin
            vic_way = ~lru_way;
        end else begin
            vic_ok = 1'b0;
        end
    end

endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wthru,
    input  logic              req_inhibit,
    input  logic              req_lock,
    input  logic              req_unlock,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WRD_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - WRD_W - BYTE_W;
    localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(WORDS - 1);

    dc_state_e state_q, state_d;

    // latched request
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic              r_write, r_lock, r_unlock, r_way;
    logic [TAG_W-1:0]  r_vtag;
    logic [WRD_W-1:0]  beat_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic [WRD_W-1:0] req_word, r_word;
    logic [IDX_W-1:0] req_idx, r_idx;
    logic [TAG_W-1:0] req_tag, r_tag;

    assign req_word = req_addr[BYTE_W +: WRD_W];
    assign req_idx  = req_addr[BYTE_W + WRD_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign r_word   = r_addr[BYTE_W +: WRD_W];
    assign r_idx    = r_addr[BYTE_W + WRD_W +: IDX_W];
    assign r_tag    = r_addr[ADDR_W-1 -: TAG_W];

    // tag store wiring
    logic [IDX_W-1:0] ts_rd_idx;
    dc_flags_t        ts_flags [2];
    logic [TAG_W-1:0] ts_tag   [2];
    logic             ts_lru;
    logic             ts_wr_en, ts_wr_way, ts_lru_en, ts_lru_way;
    logic [IDX_W-1:0] ts_wr_idx, ts_lru_idx;
    dc_flags_t        ts_wr_flags;
    logic [TAG_W-1:0] ts_wr_tag;

    // data store wiring
    logic              ds_rd_way, ds_wr_en, ds_wr_way;
    logic [IDX_W-1:0]  ds_rd_idx, ds_wr_idx;
    logic [WRD_W-1:0]  ds_rd_word, ds_wr_word;
    logic [DATA_W-1:0] ds_rd_data, ds_wr_data;

    dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (ts_rd_idx),
        .rd_flags    (ts_flags),
        .rd_tag      (ts_tag),
        .rd_lru      (ts_lru),
        .wr_en       (ts_wr_en),
        .wr_idx      (ts_wr_idx),
        .wr_way      (ts_wr_way),
        .wr_flags    (ts_wr_flags),
        .wr_tag      (ts_wr_tag),
        .lru_en      (ts_lru_en),
        .lru_idx     (ts_lru_idx),
        .lru_used_way(ts_lru_way)
    );

    dc_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W),
                    .IDX_W(IDX_W), .WRD_W(WRD_W)) i_data (
        .clk    (clk),
        .rd_way (ds_rd_way),
        .rd_idx (ds_rd_idx),
        .rd_word(ds_rd_word),
        .rd_data(ds_rd_data),
        .wr_en  (ds_wr_en),
        .wr_way (ds_wr_way),
        .wr_idx (ds_wr_idx),
        .wr_word(ds_wr_word),
        .wr_data(ds_wr_data)
    );

    // lookup
    logic [1:0] hit_w, valid_vec, lk_vec;
    logic       hit, hit_way, vic_ok, vic_way;
    logic       accept, look, wt_write;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_w[w]     = ts_flags[w].valid && (ts_tag[w] == req_tag);
        assign valid_vec[w] = ts_flags[w].valid;
        assign lk_vec[w]    = ts_flags[w].lock;
    end

    assign hit       = |hit_w;
    assign hit_way   = hit_w[1];
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign look      = accept && !req_inhibit;
    assign wt_write  = req_write && req_wthru;
    assign ts_rd_idx = (state_q == ST_IDLE) ? req_idx : r_idx;

    dc_victim_sel i_victim (
        .valid_vec(valid_vec),
        .lock_vec (lk_vec),
        .lru_way  (ts_lru),
        .vic_ok   (vic_ok),
        .vic_way  (vic_way)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_inhibit)                         state_d = ST_SINGLE;
                    else if (hit)                            state_d = wt_write ? ST_SINGLE : ST_IDLE;
                    else if (wt_write || !vic_ok)            state_d = ST_SINGLE;
                    else if (ts_flags[vic_way].valid &&
                             ts_flags[vic_way].dirty)        state_d = ST_WBACK;
                    else                                     state_d = ST_FILL;
                end
            end
            ST_WBACK:  if (mem_ack && beat_q == LAST_BEAT) state_d = ST_FILL;
            ST_FILL:   if (mem_ack && beat_q == LAST_BEAT) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_SINGLE: if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and array controls
    always_comb begin
        mem_req     = 1'b0;
        mem_write   = 1'b0;
        mem_burst   = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        ds_rd_way   = hit_way;
        ds_rd_idx   = req_idx;
        ds_rd_word  = req_word;
        ds_wr_en    = 1'b0;
        ds_wr_way   = r_way;
        ds_wr_idx   = r_idx;
        ds_wr_word  = beat_q;
        ds_wr_data  = mem_rdata;
        ts_wr_en    = 1'b0;
        ts_wr_idx   = r_idx;
        ts_wr_way   = r_way;
        ts_wr_flags = '0;
        ts_wr_tag   = r_tag;
        ts_lru_en   = 1'b0;
        ts_lru_idx  = r_idx;
        ts_lru_way  = r_way;
        unique case (state_q)
            ST_IDLE: begin
                if (look && hit) begin
                    ts_wr_en          = 1'b1;
                    ts_wr_idx         = req_idx;
                    ts_wr_way         = hit_way;
                    ts_wr_tag         = req_tag;
                    ts_wr_flags.valid = 1'b1;
                    ts_wr_flags.dirty = ts_flags[hit_way].dirty | (req_write & ~req_wthru);
                    ts_wr_flags.lock  = (ts_flags[hit_way].lock | req_lock) & ~req_unlock;
                    ts_lru_en         = 1'b1;
                    ts_lru_idx        = req_idx;
                    ts_lru_way        = hit_way;
                    if (req_write) begin
                        ds_wr_en   = 1'b1;
                        ds_wr_way  = hit_way;
                        ds_wr_idx  = req_idx;
                        ds_wr_word = req_word;
                        ds_wr_data = req_wdata;
                    end
                end
            end
            ST_WBACK: begin
                ds_rd_way  = r_way;
                ds_rd_idx  = r_idx;
                ds_rd_word = beat_q;
                mem_req    = 1'b1;
                mem_write  = 1'b1;
                mem_burst  = 1'b1;
                mem_addr   = {r_vtag, r_idx, beat_q, {BYTE_W{1'b0}}};
                mem_wdata  = ds_rd_data;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {r_tag, r_idx, beat_q, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    ds_wr_en = 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        ts_wr_en          = 1'b1;
                        ts_wr_flags.valid = 1'b1;
                        ts_wr_flags.dirty = 1'b0;
                        ts_wr_flags.lock  = r_lock & ~r_unlock;
                    end
                end
            end
            ST_DONE: begin
                ds_rd_way  = r_way;
                ds_rd_idx  = r_idx;
                ds_rd_word = r_word;
                ts_lru_en  = 1'b1;
                if (r_write) begin
                    ds_wr_en          = 1'b1;
                    ds_wr_word        = r_word;
                    ds_wr_data        = r_wdata;
                    ts_wr_en          = 1'b1;
                    ts_wr_flags.valid = 1'b1;
                    ts_wr_flags.dirty = 1'b1;
                    ts_wr_flags.lock  = ts_flags[r_way].lock;
                end
            end
            ST_SINGLE: begin
                mem_req   = 1'b1;
                mem_write = r_write;
                mem_addr  = r_addr;
                mem_wdata = r_wdata;
            end
            default: ;
        endcase
    end

    // request latch, beat counter and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr      <= '0;
            r_wdata     <= '0;
            r_write     <= 1'b0;
            r_lock      <= 1'b0;
            r_unlock    <= 1'b0;
            r_way       <= 1'b0;
            r_vtag      <= '0;
            beat_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                r_addr   <= req_addr;
                r_wdata  <= req_wdata;
                r_write  <= req_write;
                r_lock   <= req_lock;
                r_unlock <= req_unlock;
                r_way    <= hit ? hit_way : vic_way;
                r_vtag   <= ts_tag[vic_way];
                beat_q   <= '0;
            end else if ((state_q == ST_WBACK || state_q == ST_FILL) && mem_ack) begin
                beat_q <= beat_q + 1'b1;
            end
            if (look && hit && !wt_write) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= ds_rd_data;
            end else if (state_q == ST_SINGLE && mem_ack) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= mem_rdata;
            end else if (state_q == ST_DONE) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= ds_rd_data;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    // R2: a hit answers in the next cycle
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (look && hit && !wt_write) |=> rsp_valid);

    // R2: a lookup never matches both ways
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        look |-> $onehot0(hit_w));

    // R3: the cycle after a refill always answers
    a_r3_done_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> rsp_valid);

    // R5: the chosen victim is not locked
    a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (look && !hit && !wt_write && vic_ok) |-> !lk_vec[vic_way]);

    // R6: a miss in a fully locked set goes uncached
    a_r6_full_lock_single: assert property (@(posedge clk) disable iff (!rst_n)
        (look && !hit && !wt_write && lk_vec == 2'b11) |=> (state_q == ST_SINGLE));

    // R8: the write-back burst hands over to a refill starting at beat 0
    a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK && mem_ack && beat_q == LAST_BEAT)
        |=> (state_q == ST_FILL && beat_q == '0));

    // R10: inhibited accesses become one non-burst transfer
    a_r10_inhibit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_inhibit) |=> (state_q == ST_SINGLE && mem_req && !mem_burst));

    // R11: memory request held steady until acknowledged
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

endmodule

// File: tb/test_dcache_2way.sv
module test_dcache_2way;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
    logic        req_inhibit = 1'b0, req_lock = 1'b0, req_unlock = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_write, mem_burst;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    dcache_2way i_dcache_2way (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wthru(req_wthru),
        .req_inhibit(req_inhibit), .req_lock(req_lock), .req_unlock(req_unlock),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;
    int ack_pct = 100;

    logic [31:0] bm     [128];
    logic [31:0] shadow [128];

    int          n_beats;
    logic [31:0] log_addr  [32];
    logic        log_wr    [32];
    logic        log_burst [32];

    function automatic int widx(logic [31:0] a);
        return int'({a[13:11], a[5:4], a[3:2]});
    endfunction

    function automatic logic [31:0] mk(int tag, int idx, int w);
        return 32'((tag << 11) | (idx << 4) | (w << 2));
    endfunction

    function automatic logic [31:0] seed_val(int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0001_0011;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: acknowledges pending requests, logs every beat
    initial begin
        logic        pend = 1'b0;
        logic [31:0] paddr = '0;
        logic        pwr = 1'b0;
        forever begin
            @(negedge clk);
            if (pend) begin
                chk("R11 held request", {31'd0, mem_req}, 32'd1);
                chk("R11 held address", mem_addr, paddr);
                chk("R11 held direction", {31'd0, mem_write}, {31'd0, pwr});
            end
            if (mem_req && ($urandom_range(99) < 32'(ack_pct))) begin
                mem_ack   = 1'b1;
                mem_rdata = bm[widx(mem_addr)];
                if (mem_write) bm[widx(mem_addr)] = mem_wdata;
                if (n_beats < 32) begin
                    log_addr[n_beats]  = mem_addr;
                    log_wr[n_beats]    = mem_write;
                    log_burst[n_beats] = mem_burst;
                end
                n_beats++;
            end else begin
                mem_ack   = 1'b0;
                mem_rdata = $urandom;
            end
            pend  = mem_req && !mem_ack;
            paddr = mem_addr;
            pwr   = mem_write;
        end
    end

    task automatic do_req(input logic w, input logic [31:0] a, input logic [31:0] d,
                          input logic wt, input logic ci, input logic lk, input logic ulk,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        n_beats     = 0;
        req_valid   = 1'b1;
        req_write   = w;
        req_addr    = a;
        req_wdata   = d;
        req_wthru   = wt;
        req_inhibit = ci;
        req_lock    = lk;
        req_unlock  = ulk;
        if (w) shadow[widx(a)] = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    task automatic rd_chk(string req, logic [31:0] a, logic ci, logic lk, logic ulk,
                          int exp_lat, int exp_beats);
        logic [31:0] rd;
        int lat;
        do_req(1'b0, a, '0, 1'b0, ci, lk, ulk, rd, lat);
        chk({req, " read data"}, rd, shadow[widx(a)]);
        if (exp_lat >= 0)   chk({req, " latency"}, 32'(lat), 32'(exp_lat));
        if (exp_beats >= 0) chk({req, " memory beats"}, 32'(n_beats), 32'(exp_beats));
    endtask

    task automatic wr_do(string req, logic [31:0] a, logic [31:0] d, logic wt, logic ci,
                         int exp_lat, int exp_beats);
        logic [31:0] rd;
        int lat;
        do_req(1'b1, a, d, wt, ci, 1'b0, 1'b0, rd, lat);
        if (exp_lat >= 0)   chk({req, " latency"}, 32'(lat), 32'(exp_lat));
        if (exp_beats >= 0) chk({req, " memory beats"}, 32'(n_beats), 32'(exp_beats));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) begin
            bm[i]     = seed_val(i);
            shadow[i] = seed_val(i);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", {31'd0, req_ready && !mem_req}, 32'd1);

        // R1 R3: first read misses and refills with an ascending burst
        rd_chk("R3 first miss", mk(0, 1, 2), 0, 0, 0, 6, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 beat address", log_addr[i], mk(0, 1, i));
            chk("R3 beat is burst read", {30'd0, log_burst[i], log_wr[i]}, 32'd2);
        end
        // R2: hits
        rd_chk("R2 hit", mk(0, 1, 1), 0, 0, 0, 1, 0);
        // R4: LRU replacement
        rd_chk("R4 fill empty way", mk(1, 1, 0), 0, 0, 0, 6, 4);
        rd_chk("R4 touch A", mk(0, 1, 0), 0, 0, 0, 1, 0);
        rd_chk("R4 evict LRU", mk(2, 1, 3), 0, 0, 0, 6, 4);
        rd_chk("R4 recent kept", mk(0, 1, 3), 0, 0, 0, 1, 0);
        rd_chk("R4 LRU was evicted", mk(1, 1, 0), 0, 0, 0, 6, 4);

        // R5: locking in set 2
        rd_chk("R5 lock fill", mk(0, 2, 0), 0, 1, 0, 6, 4);
        rd_chk("R5 second way", mk(1, 2, 0), 0, 0, 0, 6, 4);
        rd_chk("R5 skip locked LRU", mk(2, 2, 1), 0, 0, 0, 6, 4);
        rd_chk("R5 locked line kept", mk(0, 2, 2), 0, 0, 0, 1, 0);
        rd_chk("R5 lock second", mk(1, 2, 1), 0, 1, 0, 6, 4);
        // R6: both locked
        rd_chk("R6 uncached miss", mk(2, 2, 1), 0, 0, 0, 2, 1);
        chk("R6 single beat", {31'd0, log_burst[0]}, 32'd0);
        rd_chk("R6 not allocated", mk(2, 2, 1), 0, 0, 0, 2, 1);
        rd_chk("R5 unlock hit", mk(0, 2, 3), 0, 0, 1, 1, 0);
        rd_chk("R5 unlocked now victim", mk(2, 2, 0), 0, 0, 0, 6, 4);
        rd_chk("R5 still locked line", mk(1, 2, 2), 0, 0, 0, 1, 0);

        // R7 R8: copy-back in set 3
        wr_do("R7 write miss allocates", mk(0, 3, 1), 32'h1111_2222, 0, 0, 6, 4);
        chk("R7 memory untouched", bm[widx(mk(0, 3, 1))], seed_val(widx(mk(0, 3, 1))));
        rd_chk("R7 read back", mk(0, 3, 1), 0, 0, 0, 1, 0);
        wr_do("R7 write hit", mk(0, 3, 3), 32'h3333_4444, 0, 0, 1, 0);
        chk("R7 memory still stale", bm[widx(mk(0, 3, 3))], seed_val(widx(mk(0, 3, 3))));
        rd_chk("R8 fill other", mk(1, 3, 0), 0, 0, 0, 6, 4);
        rd_chk("R8 dirty eviction", mk(2, 3, 2), 0, 0, 0, 10, 8);
        for (int i = 0; i < 4; i++) begin
            chk("R8 write-back address", log_addr[i], mk(0, 3, i));
            chk("R8 write-back first", {30'd0, log_burst[i], log_wr[i]}, 32'd3);
            chk("R8 refill after", log_addr[i + 4], mk(2, 3, i));
            chk("R8 refill is read", {31'd0, log_wr[i + 4]}, 32'd0);
        end
        chk("R8 memory updated w1", bm[widx(mk(0, 3, 1))], 32'h1111_2222);
        chk("R8 memory updated w3", bm[widx(mk(0, 3, 3))], 32'h3333_4444);

        // R9: write-through in set 0
        rd_chk("R9 fill", mk(0, 0, 0), 0, 0, 0, 6, 4);
        wr_do("R9 write hit", mk(0, 0, 2), 32'h5555_6666, 1, 0, 2, 1);
        chk("R9 memory written", bm[widx(mk(0, 0, 2))], 32'h5555_6666);
        rd_chk("R9 line updated", mk(0, 0, 2), 0, 0, 0, 1, 0);
        wr_do("R9 write miss", mk(1, 0, 1), 32'h7777_8888, 1, 0, 2, 1);
        chk("R9 miss memory written", bm[widx(mk(1, 0, 1))], 32'h7777_8888);
        rd_chk("R9 no allocation", mk(1, 0, 1), 0, 0, 0, 6, 4);

        // R10: inhibit
        rd_chk("R10 inhibited read", mk(6, 0, 3), 1, 0, 0, 2, 1);
        rd_chk("R10 not allocated", mk(6, 0, 3), 1, 0, 0, 2, 1);
        wr_do("R10 inhibited write", mk(7, 1, 0), 32'h9999_AAAA, 0, 1, 2, 1);
        chk("R10 memory written", bm[widx(mk(7, 1, 0))], 32'h9999_AAAA);

        // random phase
        ack_pct = 70;
        for (int n = 0; n < 3000; n++) begin
            int r, tg, ix, wd;
            logic [31:0] a, d;
            r  = int'($urandom_range(99));
            tg = int'($urandom_range(5));
            ix = int'($urandom_range(3));
            wd = int'($urandom_range(3));
            a  = mk(tg, ix, wd);
            d  = $urandom;
            if (r < 50) begin
                rd_chk("R2 random read", a, 0, ($urandom_range(99) < 5) ? 1'b1 : 1'b0,
                       ($urandom_range(99) < 10) ? 1'b1 : 1'b0, -1, -1);
            end else if (r < 80) begin
                wr_do("R7 random copy-back write", a, d, 0, 0, -1, -1);
            end else if (r < 95) begin
                wr_do("R9 random write-through", a, d, 1, 0, -1, -1);
                chk("R9 random memory", bm[widx(a)], d);
            end else begin
                a = mk(6 + (r & 1), ix, wd);
                if (wd[0]) begin
                    wr_do("R10 random inhibited write", a, d, 0, 1, -1, 1);
                    chk("R10 random memory", bm[widx(a)], d);
                end else begin
                    rd_chk("R10 random inhibited read", a, 1, 0, 0, -1, 1);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule